// File: doc/BRIEF.md
# Parallel EEPROM Write Capture and Program Sequencer

This block sits behind the control pins of a byte-wide parallel EEPROM and runs on a fast internal clock. It brings the active-low chip-enable, output-enable and write-enable pins into the clock domain and decides when a real write strobe has happened. It captures the address and data of that write at the edges a parallel EEPROM defines. It then waits for the host to stop loading bytes before it starts internal programming.

A write strobe exists only while chip-enable and write-enable are both low and output-enable is high. The address is taken when the strobe opens, which is the later of the two falling edges. The data is taken when the strobe closes, which is the earlier of the two rising edges. A strobe that is too short is discarded as a glitch. Each accepted write re-arms a byte-load timer. The timer is held clear while a strobe is open. When it runs out, a one-cycle program-start pulse is issued and the busy flag stays high for the programming time. Writes are refused while the block is busy and during a fixed lockout period after reset.

Top module: `prog_latch_ctrl`

## Requirements
- R1: After reset, `wr_addr` and `wr_data` are zero and `prog_start` and `busy` are low.
- R2: A strobe is open only while `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe that ends with `oe_n` going low, or that occurs while `oe_n` is low, changes no output.
- R3: `wr_addr` takes the `addr_in` value present when the synchronized strobe opens. This is the later of the `ce_n` and `we_n` falling edges.
- R4: `wr_data` takes the `data_in` value present when the synchronized strobe closes. This is the earlier of the `ce_n` and `we_n` rising edges. `wr_addr` and `wr_data` change only when a write is accepted.
- R5: A strobe that stays open for fewer than `MIN_PULSE` synchronized cycles is ignored. A strobe of exactly `MIN_PULSE` cycles is accepted.
- R6: Each accepted write restarts the load timer from zero. `prog_start` pulses for one cycle when the timer reaches `LOAD_CYCLES` without a new write, so a burst of writes yields one pulse.
- R7: `busy` rises in the same cycle as `prog_start` and stays high for exactly `PROG_CYCLES` cycles.
- R8: Writes that complete within `INHIBIT_CYCLES` cycles after reset are ignored.
- R9: Writes that complete while `busy` is high are ignored.
- R10: While a strobe is open, the load timer is held at zero. It counts afresh once the strobe closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip-enable pin, active low, asynchronous |
| oe_n | input | 1 | Output-enable pin, active low, asynchronous |
| we_n | input | 1 | Write-enable pin, active low, asynchronous |
| addr_in | input | AW | Address pins |
| data_in | input | DW | Data pins, input direction |
| wr_addr | output | AW | Address of the last accepted write |
| wr_data | output | DW | Data of the last accepted write |
| prog_start | output | 1 | One-cycle pulse that starts internal programming |
| busy | output | 1 | High while programming is in progress |

## Verification
The hardest case to reach is a load timer that is held by an open strobe which is never accepted. The bench drives a real write and then opens a long strobe. It drops `oe_n` before it releases `ce_n` and `we_n`, so the strobe closes without a capture. It then checks that no program pulse appears during the hold and that the pulse arrives a full load period after the strobe closes. Strobes that sit exactly at the minimum-length boundary, and a strobe completed in the middle of programming, are driven with exact pin-cycle counts.

// File: rtl/prog_latch_pkg.sv
package prog_latch_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } ctl_pins_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strobe_qual.sv
module strobe_qual
  import prog_latch_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_pins_t       pins_s,
  input  logic [AW-1:0]   addr_in,
  input  logic [DW-1:0]   data_in,
  input  logic            blocked,
  input  logic            busy_in,
  output logic            strobe_open,
  output logic            accept,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data
);
  localparam int LW = $clog2(MIN_PULSE + 1);
  localparam logic [LW-1:0] LEN_MAX = LW'(MIN_PULSE);

  logic            open_q;
  logic [LW-1:0]   len_q, len_d;
  logic [AW-1:0]   shadow_q, shadow_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   data_q, data_d;
  logic            opening, closing, closed_by_strobe;

  always_comb begin
    strobe_open      = ~pins_s.ce_n & ~pins_s.we_n & pins_s.oe_n;
    opening          = strobe_open & ~open_q;
    closing          = ~strobe_open & open_q;
    closed_by_strobe = pins_s.ce_n | pins_s.we_n;
    accept           = closing & closed_by_strobe & (len_q >= LEN_MAX) & ~blocked;

    len_d = '0;
    if (strobe_open) len_d = (len_q == LEN_MAX) ? len_q : len_q + 1'b1;

    shadow_d = opening ? addr_in : shadow_q;
    addr_d   = accept ? shadow_q : addr_q;
    data_d   = accept ? data_in  : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      len_q    <= '0;
      shadow_q <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      open_q   <= strobe_open;
      len_q    <= len_d;
      shadow_q <= shadow_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R5: no write is taken from a strobe shorter than the minimum
  a_r5_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (len_q >= LEN_MAX));
  // R9: never accept while programming is in progress
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy_in);
  // R4: the captured outputs only move on an accepted write
  a_r4_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/load_timer.sv
module load_timer #(
  parameter int LOAD_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic hold,
  output logic expire
);
  localparam int TW = $clog2(LOAD_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(LOAD_CYCLES - 1);

  logic          pend_q, pend_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (accept) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end else if (hold) begin
      cnt_d  = '0;
    end else if (pend_q) begin
      if (cnt_q == LAST) begin
        expire = 1'b1;
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  // R10: an open strobe keeps the count at zero
  a_r10_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !accept) |=> (cnt_q == '0));
  // R6: expiry only follows a pending load
  a_r6_expire_pending: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> pend_q);
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int PROG_CYCLES = 250000,
  parameter int INHIBIT_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic prog_start,
  output logic busy,
  output logic inhibit
);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int IW = $clog2(INHIBIT_CYCLES + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PROG_CYCLES - 1);
  localparam logic [IW-1:0] I_LAST = IW'(INHIBIT_CYCLES - 1);

  logic          start_q, busy_q, busy_d, inh_q, inh_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [IW-1:0] ic_q, ic_d;

  always_comb begin
    busy_d = busy_q;
    pc_d   = pc_q;
    if (expire) begin
      busy_d = 1'b1;
      pc_d   = '0;
    end else if (busy_q) begin
      if (pc_q == P_LAST) busy_d = 1'b0;
      else                pc_d   = pc_q + 1'b1;
    end

    inh_d = inh_q;
    ic_d  = ic_q;
    if (inh_q) begin
      if (ic_q == I_LAST) inh_d = 1'b0;
      else                ic_d  = ic_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      pc_q    <= '0;
      inh_q   <= 1'b1;
      ic_q    <= '0;
    end else begin
      start_q <= expire;
      busy_q  <= busy_d;
      pc_q    <= pc_d;
      inh_q   <= inh_d;
      ic_q    <= ic_d;
    end
  end

  assign prog_start = start_q;
  assign busy       = busy_q;
  assign inhibit    = inh_q;

  // R7: busy is raised together with the start pulse
  a_r7_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy);
  // R6: the start pulse lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  // R8: once the lockout ends it never returns
  a_r8_inhibit_once: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |=> !inhibit);
endmodule

// File: rtl/prog_latch_ctrl.sv
module prog_latch_ctrl
  import prog_latch_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE = 3,
  parameter int LOAD_CYCLES = 5000,
  parameter int PROG_CYCLES = 250000,
  parameter int INHIBIT_CYCLES = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          prog_start,
  output logic          busy
);
  localparam int PIN_W = $bits(ctl_pins_t);

  ctl_pins_t pins_raw, pins_s;
  logic      strobe_open, accept, expire, inhibit, blocked;

  assign pins_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};
  assign blocked  = inhibit | busy;

  pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  strobe_qual #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .addr_in(addr_in),
    .data_in(data_in), .blocked(blocked), .busy_in(busy),
    .strobe_open(strobe_open), .accept(accept),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  load_timer #(.LOAD_CYCLES(LOAD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hold(strobe_open),
    .expire(expire)
  );

  prog_seq #(.PROG_CYCLES(PROG_CYCLES), .INHIBIT_CYCLES(INHIBIT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .prog_start(prog_start),
    .busy(busy), .inhibit(inhibit)
  );

  // R8: nothing is accepted during the power-up lockout
  a_r8_no_accept_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !inhibit);
  // R7: programming cannot restart while already busy
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !expire);
endmodule

// File: tb/sim_prog_latch_ctrl.sv
module sim_prog_latch_ctrl;
  localparam int AW = 13, DW = 8, MINP = 3, LOAD = 40, PROG = 60, INH = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic prog_start, busy;

  int checks = 0, errors = 0, ps_cnt = 0, busy_cnt = 0;

  always #5 clk = ~clk;

  prog_latch_ctrl #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .MIN_PULSE(MINP),
    .LOAD_CYCLES(LOAD), .PROG_CYCLES(PROG), .INHIBIT_CYCLES(INH)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_in(addr_in), .data_in(data_in), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start), .busy(busy)
  );

  // behavioural reference, updated once per rising edge
  logic [2:0] p1, p2;
  bit m_open, m_pend, m_busy, m_inh, m_ps;
  int m_len, m_cnt, m_pc, m_ic;
  logic [AW-1:0] m_sh, m_addr;
  logic [DW-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 3'b111; p2 = 3'b111; m_open = 0; m_pend = 0; m_busy = 0; m_inh = 1;
      m_ps = 0; m_len = 0; m_cnt = 0; m_pc = 0; m_ic = 0;
      m_sh = '0; m_addr = '0; m_data = '0;
    end else begin
      bit op, acc, ex;
      op  = !p2[2] && !p2[0] && p2[1];
      acc = !op && m_open && (p2[2] || p2[0]) && m_len >= MINP && !m_inh && !m_busy;
      ex  = !acc && !op && m_pend && m_cnt == LOAD - 1;
      if (op && !m_open) m_sh = addr_in;
      if (acc) begin m_addr = m_sh; m_data = data_in; end
      m_len  = op ? ((m_len < MINP) ? m_len + 1 : m_len) : 0;
      m_open = op;
      if (acc) begin m_pend = 1; m_cnt = 0; end
      else if (op) m_cnt = 0;
      else if (ex) begin m_pend = 0; m_cnt = 0; end
      else if (m_pend) m_cnt++;
      if (ex) begin m_busy = 1; m_pc = 0; end
      else if (m_busy) begin
        if (m_pc == PROG - 1) m_busy = 0; else m_pc++;
      end
      m_ps = ex;
      if (m_inh) begin
        if (m_ic == INH - 1) m_inh = 0; else m_ic++;
      end
      p2 = p1; p1 = {ce_n, oe_n, we_n};
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (wr_addr !== m_addr) begin errors++; $display("FAIL R3 wr_addr act=%h exp=%h", wr_addr, m_addr); end
    if (wr_data !== m_data) begin errors++; $display("FAIL R4 wr_data act=%h exp=%h", wr_data, m_data); end
    if (prog_start !== m_ps) begin errors++; $display("FAIL R6 prog_start act=%b exp=%b", prog_start, m_ps); end
    if (busy !== m_busy) begin errors++; $display("FAIL R7 busy act=%b exp=%b", busy, m_busy); end
    if (prog_start === 1'b1) ps_cnt++;
    if (busy === 1'b1) busy_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // write-enable controlled write of n pin cycles
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
    addr_in = a; data_in = d; ce_n = 1'b0; cyc(2);
    we_n = 1'b0; cyc(n);
    we_n = 1'b1; cyc(4);
    ce_n = 1'b1; cyc(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ps0, b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 wr_addr", wr_addr, 0); chk("R1 wr_data", wr_data, 0);
    chk("R1 prog_start", prog_start, 0); chk("R1 busy", busy, 0);

    // R8 write inside the lockout
    wr(13'h0aaa, 8'h55, 6);
    cyc(LOAD + 20);
    chk("R8 addr", wr_addr, 0); chk("R8 pulses", ps_cnt, 0);

    // plain write, program, busy length
    ps0 = ps_cnt; b0 = busy_cnt;
    wr(13'h0123, 8'ha5, 6);
    chk("R3 addr", wr_addr, 13'h0123); chk("R4 data", wr_data, 8'ha5);
    cyc(LOAD + PROG + 20);
    chk("R6 one pulse", ps_cnt - ps0, 1);
    chk("R7 busy length", busy_cnt - b0, PROG);

    // R6 burst of writes retriggers the timer
    ps0 = ps_cnt;
    wr(13'h0011, 8'h01, 5); cyc(LOAD / 2);
    wr(13'h0022, 8'h02, 5); cyc(LOAD / 2);
    wr(13'h0033, 8'h03, 5);
    cyc(LOAD + PROG + 20);
    chk("R6 burst pulses", ps_cnt - ps0, 1);
    chk("R6 last data", wr_data, 8'h03);

    // R3 later falling edge, R4 earlier rising edge (chip-enable controlled)
    addr_in = 13'h0100; data_in = 8'h11; we_n = 1'b0; cyc(8);
    addr_in = 13'h0200; ce_n = 1'b0; cyc(6);
    addr_in = 13'h0300; cyc(4);
    ce_n = 1'b1; cyc(6);
    data_in = 8'h22; we_n = 1'b1; cyc(4);
    chk("R3 later fall", wr_addr, 13'h0200);
    chk("R4 earlier rise", wr_data, 8'h11);
    cyc(LOAD + PROG + 20);

    // R5 short strobe rejected, boundary accepted
    ps0 = ps_cnt;
    wr(13'h0444, 8'h44, MINP - 1);
    chk("R5 short addr", wr_addr, 13'h0200);
    cyc(LOAD + 10);
    chk("R5 short no pulse", ps_cnt - ps0, 0);
    wr(13'h0555, 8'h55, MINP);
    chk("R5 boundary addr", wr_addr, 13'h0555);
    cyc(LOAD + PROG + 20);

    // R2 strobe with output-enable low
    ps0 = ps_cnt;
    oe_n = 1'b0; wr(13'h0666, 8'h66, 6); oe_n = 1'b1; cyc(2);
    chk("R2 oe low addr", wr_addr, 13'h0555);
    chk("R2 oe low data", wr_data, 8'h55);
    cyc(LOAD + 10);
    chk("R2 no pulse", ps_cnt - ps0, 0);

    // R10 timer held by an open strobe that is then aborted
    ps0 = ps_cnt;
    wr(13'h0777, 8'h77, 6);
    addr_in = 13'h0888; data_in = 8'h88; ce_n = 1'b0; we_n = 1'b0;
    cyc(LOAD + 20);
    chk("R10 held no pulse", ps_cnt - ps0, 0);
    oe_n = 1'b0; cyc(4);
    ce_n = 1'b1; we_n = 1'b1; cyc(4);
    oe_n = 1'b1;
    cyc(LOAD - 15);
    chk("R10 restart no early pulse", ps_cnt - ps0, 0);
    cyc(30);
    chk("R10 pulse after release", ps_cnt - ps0, 1);
    chk("R2 aborted addr", wr_addr, 13'h0777);

    // R9 write while busy
    cyc(5);
    chk("R9 busy now", busy, 1);
    ps0 = ps_cnt;
    wr(13'h0999, 8'h99, 6);
    chk("R9 addr kept", wr_addr, 13'h0777);
    chk("R9 data kept", wr_data, 8'h77);
    cyc(PROG + LOAD + 20);
    chk("R9 no pulse", ps_cnt - ps0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule